// File: doc/BRIEF.md
# Gyro SPI Command Frame Engine

This block is the host side of a 32-bit framed SPI link to a digital angular-rate sensor. A local requester hands it one of three operations: read a 16-bit register, write a 16-bit register, or fetch the current rate sample. The engine builds the 32-bit command word, adds an odd-parity bit and shifts the word out MSB first in SPI mode 0. It then obtains the sensor's answer and returns the extracted value, the status pair and the error field, together with a one-cycle completion pulse.

The sensor answers a command in the frame that follows it. Every read therefore costs two chip-select framed transfers: the command frame, a chip-select high gap, and a fetch frame whose MOSI bits are all zero and whose MISO bits are the reply. A write needs only one frame, but the sensor needs a settling interval after it. The engine holds chip select high for a parameterised guard time before it reports completion, so the next transfer cannot start too early.

Top module: `gyro_frame_eng`

## Requirements
- R1: Command bits [31:29] carry the operation code: req_op_i 2'b00 (register read) sends 3'b100, 2'b01 (register write) sends 3'b010, and 2'b10 or 2'b11 (rate fetch) sends 3'b001.
- R2: In register commands the 8-bit address sits in bits [24:17]. In a write the 16-bit data sits in bits [16:1]. Every other bit except bit 0 is zero, and a rate fetch has only its opcode bit set above bit 0.
- R3: Bit 0 of each command is set exactly when bits [31:1] hold an even number of ones, so every command word has odd parity.
- R4: Frames use SPI mode 0. SCLK idles low whenever chip select is high. MOSI changes only after falling SCLK edges and is sampled on rising edges, MSB first, 32 bits per frame. Each SCLK half period is CLK_DIV clock cycles.
- R5: A read issues exactly two frames: the command, then a fetch frame with all-zero MOSI. The reply is the MISO word of the second frame. A write issues exactly one frame.
- R6: On register read completion, rsp_data_o equals reply bits [20:5].
- R7: On rate fetch completion, rsp_data_o equals reply bits [25:10], a signed value.
- R8: On read completion, rsp_status_o equals reply bits [27:26], rsp_errf_o equals reply bits [31:29], and err_o is high exactly when that error field is nonzero.
- R9: Chip select stays high for at least 2*CLK_DIV cycles (one SCLK period) between any two frames.
- R10: After a write frame, chip select stays high for at least WR_GUARD_CYC cycles before the next frame. The write completes with rsp_data_o, rsp_status_o, rsp_errf_o and err_o all zero.
- R11: req_ready_o is high only when idle, and a request is taken when req_valid_i and req_ready_o are both high. busy_o is high from acceptance to completion, and requests presented while busy produce no frames and no change. done_o is a single-cycle pulse.
- R12: Under reset cs_no is 1, sclk_o is 0, busy_o and done_o are 0, and req_ready_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request strobe |
| req_ready_o | output | 1 | Engine idle, request accepted this cycle if valid |
| req_op_i | input | 2 | 00 register read, 01 register write, 10/11 rate fetch |
| req_addr_i | input | 8 | Register address |
| req_wdata_i | input | 16 | Register write data |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Reply error field nonzero |
| rsp_data_o | output | 16 | Extracted 16-bit value |
| rsp_status_o | output | 2 | Reply status pair |
| rsp_errf_o | output | 3 | Reply error field |
| sclk_o | output | 1 | SPI clock, mode 0 |
| cs_no | output | 1 | Active-low chip select |
| mosi_o | output | 1 | Serial data to sensor |
| miso_i | input | 1 | Serial data from sensor |

## Verification
For a read, the results are due in the cycle where done_o pulses. That cycle comes two frames of 64*CLK_DIV cycles each, plus two chip-select gaps, after acceptance. For a write, done_o comes after one frame plus the write guard. The bench never counts to a fixed cycle. It waits for done_o, samples all response outputs on the falling clock edge of that same cycle, and checks them against values computed from the reply word it loaded into its sensor model. Chip-select gaps are measured by counting the rising clock edges on which cs_no is high before each falling edge of chip select, and that count is compared with the minimum that the previous frame type requires.

// File: rtl/gfe_pkg.sv
package gfe_pkg;
  localparam int FRAME_W = 32;
  localparam int ADDR_W  = 8;
  localparam int DATA_W  = 16;

  typedef enum logic [1:0] {
    OP_REG_RD  = 2'd0,
    OP_REG_WR  = 2'd1,
    OP_RATE_RD = 2'd2,
    OP_RATE_AL = 2'd3
  } gfe_op_e;

  localparam logic [2:0] HDR_RATE = 3'b001;
  localparam logic [2:0] HDR_WR   = 3'b010;
  localparam logic [2:0] HDR_RD   = 3'b100;

  // field positions in command and reply
  localparam int ADDR_LSB = 17;
  localparam int WDAT_LSB = 1;
  localparam int RREG_LSB = 5;
  localparam int RATE_LSB = 10;
  localparam int STAT_LSB = 26;
  localparam int ERRF_LSB = 29;
endpackage

// File: rtl/gfe_cmd_build.sv
module gfe_cmd_build
  import gfe_pkg::*;
(
  input  gfe_op_e              op_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [DATA_W-1:0]    wdata_i,
  output logic [FRAME_W-1:0]   word_o
);
  logic [FRAME_W-1:0] body;

  always_comb begin
    body = '0;
    unique case (op_i)
      OP_REG_RD: begin
        body[FRAME_W-1 -: 3]           = HDR_RD;
        body[ADDR_LSB +: ADDR_W]       = addr_i;
      end
      OP_REG_WR: begin
        body[FRAME_W-1 -: 3]           = HDR_WR;
        body[ADDR_LSB +: ADDR_W]       = addr_i;
        body[WDAT_LSB +: DATA_W]       = wdata_i;
      end
      default: body[FRAME_W-1 -: 3]    = HDR_RATE;
    endcase
    // parity bit makes total ones odd
    word_o = {body[FRAME_W-1:1], ~^body[FRAME_W-1:1]};
  end
endmodule

// File: rtl/gfe_spi_shift.sv
module gfe_spi_shift
  import gfe_pkg::*;
#(
  parameter int CLK_DIV = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [FRAME_W-1:0] tx_word_i,
  output logic               fin_o,
  output logic [FRAME_W-1:0] rx_word_o,
  output logic               sclk_o,
  output logic               cs_no,
  output logic               mosi_o,
  input  logic               miso_i
);
  localparam int DW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam int BW = $clog2(FRAME_W);

  logic               active_q;
  logic [DW-1:0]      div_q;
  logic [BW-1:0]      bit_q;
  logic [FRAME_W-1:0] tx_q, rx_q;
  logic               half_end;

  assign half_end = (div_q == DW'(CLK_DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      div_q    <= '0;
      bit_q    <= '0;
      tx_q     <= '0;
      rx_q     <= '0;
      sclk_o   <= 1'b0;
      fin_o    <= 1'b0;
    end else begin
      fin_o <= 1'b0;
      if (!active_q) begin
        if (start_i) begin
          active_q <= 1'b1;
          tx_q     <= tx_word_i;
          div_q    <= '0;
          bit_q    <= '0;
          sclk_o   <= 1'b0;
        end
      end else if (half_end) begin
        div_q <= '0;
        if (!sclk_o) begin
          sclk_o <= 1'b1;
          rx_q   <= {rx_q[FRAME_W-2:0], miso_i};
        end else begin
          sclk_o <= 1'b0;
          if (bit_q == BW'(FRAME_W - 1)) begin
            active_q <= 1'b0;
            fin_o    <= 1'b1;
          end else begin
            bit_q <= bit_q + 1'b1;
            tx_q  <= {tx_q[FRAME_W-2:0], 1'b0};
          end
        end
      end else begin
        div_q <= div_q + 1'b1;
      end
    end
  end

  assign cs_no     = ~active_q;
  assign mosi_o    = tx_q[FRAME_W-1];
  assign rx_word_o = rx_q;

  p_sclk_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> !sclk_o);
  p_mosi_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sclk_o) |-> $stable(mosi_o));
endmodule

// File: rtl/gfe_reply_dec.sv
module gfe_reply_dec
  import gfe_pkg::*;
(
  input  gfe_op_e            op_i,
  input  logic [FRAME_W-1:0] rx_word_i,
  output logic [DATA_W-1:0]  data_o,
  output logic [1:0]         status_o,
  output logic [2:0]         errf_o,
  output logic               err_o
);
  logic unused_bits;
  assign unused_bits = ^{rx_word_i[28], rx_word_i[4:0]};

  always_comb begin
    data_o   = '0;
    status_o = '0;
    errf_o   = '0;
    if (op_i != OP_REG_WR) begin
      data_o   = (op_i == OP_REG_RD) ? rx_word_i[RREG_LSB +: DATA_W]
                                     : rx_word_i[RATE_LSB +: DATA_W];
      status_o = rx_word_i[STAT_LSB +: 2];
      errf_o   = rx_word_i[ERRF_LSB +: 3];
    end
    err_o = |errf_o;
  end
endmodule

// File: rtl/gyro_frame_eng.sv
module gyro_frame_eng
  import gfe_pkg::*;
#(
  parameter int CLK_DIV      = 4,
  parameter int WR_GUARD_CYC = 10000
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  output logic               req_ready_o,
  input  logic [1:0]         req_op_i,
  input  logic [ADDR_W-1:0]  req_addr_i,
  input  logic [DATA_W-1:0]  req_wdata_i,
  output logic               busy_o,
  output logic               done_o,
  output logic               err_o,
  output logic [DATA_W-1:0]  rsp_data_o,
  output logic [1:0]         rsp_status_o,
  output logic [2:0]         rsp_errf_o,
  output logic               sclk_o,
  output logic               cs_no,
  output logic               mosi_o,
  input  logic               miso_i
);
  localparam int GAP_CYC = 2 * CLK_DIV;
  localparam int WMAX    = (WR_GUARD_CYC > GAP_CYC) ? WR_GUARD_CYC : GAP_CYC;
  localparam int CW      = $clog2(WMAX + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_FRAME, ST_WAIT} st_e;

  st_e                state_q;
  gfe_op_e            op_q;
  logic               second_q, last_q;
  logic [CW-1:0]      cnt_q, tgt_q;
  logic [FRAME_W-1:0] cmd_word, tx_word, rx_word;
  logic               start, fin, wait_end;
  logic [DATA_W-1:0]  dec_data;
  logic [1:0]         dec_stat;
  logic [2:0]         dec_errf;
  logic               dec_err;

  gfe_cmd_build u_build (
    .op_i    (gfe_op_e'(req_op_i)),
    .addr_i  (req_addr_i),
    .wdata_i (req_wdata_i),
    .word_o  (cmd_word)
  );

  assign wait_end = (state_q == ST_WAIT) && (cnt_q == tgt_q - CW'(1));
  assign start    = ((state_q == ST_IDLE) && req_valid_i) || (wait_end && !last_q);
  // fetch frame clocks zeros
  assign tx_word  = (state_q == ST_IDLE) ? cmd_word : '0;

  gfe_spi_shift #(.CLK_DIV(CLK_DIV)) u_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .tx_word_i (tx_word),
    .fin_o     (fin),
    .rx_word_o (rx_word),
    .sclk_o    (sclk_o),
    .cs_no     (cs_no),
    .mosi_o    (mosi_o),
    .miso_i    (miso_i)
  );

  gfe_reply_dec u_dec (
    .op_i      (op_q),
    .rx_word_i (rx_word),
    .data_o    (dec_data),
    .status_o  (dec_stat),
    .errf_o    (dec_errf),
    .err_o     (dec_err)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      op_q         <= OP_RATE_RD;
      second_q     <= 1'b0;
      last_q       <= 1'b0;
      cnt_q        <= '0;
      tgt_q        <= CW'(1);
      done_o       <= 1'b0;
      err_o        <= 1'b0;
      rsp_data_o   <= '0;
      rsp_status_o <= '0;
      rsp_errf_o   <= '0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (req_valid_i) begin
          op_q     <= gfe_op_e'(req_op_i);
          second_q <= 1'b0;
          state_q  <= ST_FRAME;
        end
        ST_FRAME: if (fin) begin
          cnt_q   <= '0;
          state_q <= ST_WAIT;
          if (op_q == OP_REG_WR) begin
            tgt_q  <= CW'(WR_GUARD_CYC);
            last_q <= 1'b1;
          end else begin
            tgt_q  <= CW'(GAP_CYC);
            last_q <= second_q;
          end
        end
        ST_WAIT: if (wait_end) begin
          if (last_q) begin
            done_o       <= 1'b1;
            err_o        <= dec_err;
            rsp_data_o   <= dec_data;
            rsp_status_o <= dec_stat;
            rsp_errf_o   <= dec_errf;
            state_q      <= ST_IDLE;
          end else begin
            second_q <= 1'b1;
            state_q  <= ST_FRAME;
          end
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o = (state_q == ST_IDLE);
  assign busy_o      = (state_q != ST_IDLE);

  p_cmd_hdr_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start && state_q == ST_IDLE) |-> ($countones(tx_word[FRAME_W-1 -: 3]) == 1));
  p_odd_parity_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start && state_q == ST_IDLE) |-> ($countones(tx_word) % 2 == 1));
  p_accept_busy_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> (busy_o && !cs_no));
  p_done_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_err_field_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && err_o) |-> (rsp_errf_o != 3'b000));
  p_gap_start_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_no) |=> cs_no);
endmodule

// File: tb/sim_gyro_frame_eng.sv
module sim_gyro_frame_eng;
  localparam int DIV   = 2;
  localparam int GUARD = 300;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [1:0] req_op = 2'd0;
  logic [7:0] req_addr = 8'd0;
  logic [15:0] req_wdata = 16'd0;
  logic req_ready, busy, done, err, sclk, cs_n, mosi;
  logic miso = 1'b0;
  logic [15:0] rsp_data;
  logic [1:0] rsp_status;
  logic [2:0] rsp_errf;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  gyro_frame_eng #(.CLK_DIV(DIV), .WR_GUARD_CYC(GUARD)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_op_i(req_op), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .busy_o(busy), .done_o(done), .err_o(err), .rsp_data_o(rsp_data),
    .rsp_status_o(rsp_status), .rsp_errf_o(rsp_errf), .sclk_o(sclk),
    .cs_no(cs_n), .mosi_o(mosi), .miso_i(miso));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // sensor model
  logic [31:0] resp_word = 32'd0;
  logic [31:0] sl_rx = 32'd0;
  int sl_bit = 31;
  logic [31:0] frm [0:255];
  int nfr = 0;
  bit prev_wr = 1'b0;
  int hi_cnt = 1000000;
  int sclk_bad = 0;

  always @(negedge cs_n) begin
    int need;
    need = prev_wr ? GUARD : 2 * DIV;
    chk(hi_cnt >= need, prev_wr ? "R10 write guard" : "R9 cs gap", hi_cnt, need);
    sl_bit = 31;
    sl_rx  = 32'd0;
    miso   = resp_word[31];
  end
  always @(posedge sclk) if (!cs_n) sl_rx = {sl_rx[30:0], mosi};
  always @(negedge sclk) if (!cs_n && sl_bit > 0) begin
    sl_bit = sl_bit - 1;
    miso   = resp_word[sl_bit];
  end
  always @(posedge cs_n) begin
    if (nfr < 256) frm[nfr] = sl_rx;
    nfr++;
    prev_wr = (sl_rx[31:29] == 3'b010);
  end
  always @(posedge clk) begin
    if (cs_n) hi_cnt++;
    else hi_cnt = 0;
  end
  always @(negedge clk) if (rst_n && cs_n && sclk) sclk_bad++;

  function automatic logic [31:0] exp_cmd(input logic [1:0] op, input logic [7:0] a, input logic [15:0] d);
    logic [31:0] w;
    int ones;
    w = 32'd0;
    if (op == 2'd0) w = 32'h8000_0000 | (32'(a) << 17);
    else if (op == 2'd1) w = 32'h4000_0000 | (32'(a) << 17) | (32'(d) << 1);
    else w = 32'h2000_0000;
    ones = 0;
    for (int i = 1; i < 32; i++) ones += int'(w[i]);
    if (ones % 2 == 0) w[0] = 1'b1;
    return w;
  endfunction

  bit wd_hit = 1'b0;

  task automatic run_txn(input logic [1:0] op, input logic [7:0] a, input logic [15:0] d,
                         input logic [31:0] rw, input bit poke);
    int f0, tmo;
    logic [31:0] ec;
    logic [15:0] ed;
    resp_word = rw;
    f0 = nfr;
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = a; req_wdata = d;
    chk(req_ready == 1'b1, "R11 ready idle", 32'(req_ready), 32'd1);
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy == 1'b1, "R11 busy after accept", 32'(busy), 32'd1);
    if (poke) begin
      repeat (10) @(negedge clk);
      req_valid = 1'b1; req_op = 2'($urandom % 4);
      req_addr = 8'($urandom); req_wdata = 16'($urandom);
      repeat (8) @(negedge clk);
      chk(req_ready == 1'b0, "R11 not ready busy", 32'(req_ready), 32'd0);
      req_valid = 1'b0;
    end
    tmo = 0;
    while (!done && tmo < 20000) begin
      @(negedge clk);
      tmo++;
    end
    if (tmo >= 20000) begin
      chk(1'b0, "R11 done timeout", 32'(tmo), 32'd0);
      return;
    end
    ec = exp_cmd(op, a, d);
    chk(nfr - f0 == ((op == 2'd1) ? 1 : 2), "R5 frame count", 32'(nfr - f0), (op == 2'd1) ? 32'd1 : 32'd2);
    chk(frm[f0 & 255][31:29] == ec[31:29], "R1 header", 32'(frm[f0 & 255][31:29]), 32'(ec[31:29]));
    chk(frm[f0 & 255][28:1] == ec[28:1], "R2 fields", frm[f0 & 255], ec);
    chk(frm[f0 & 255][0] == ec[0], "R3 parity", 32'(frm[f0 & 255][0]), 32'(ec[0]));
    chk(frm[f0 & 255] == ec, "R4 serial word", frm[f0 & 255], ec);
    if (op == 2'd1) begin
      chk({rsp_data, rsp_status, rsp_errf, err} == 22'd0, "R10 write result",
          32'({rsp_data, rsp_status, rsp_errf, err}), 32'd0);
    end else begin
      chk(frm[(f0 + 1) & 255] == 32'd0, "R5 fetch zeros", frm[(f0 + 1) & 255], 32'd0);
      ed = (op == 2'd0) ? rw[20:5] : rw[25:10];
      chk(rsp_data == ed, (op == 2'd0) ? "R6 reg data" : "R7 rate data", 32'(rsp_data), 32'(ed));
      chk(rsp_status == rw[27:26], "R8 status", 32'(rsp_status), 32'(rw[27:26]));
      chk(rsp_errf == rw[31:29], "R8 errf", 32'(rsp_errf), 32'(rw[31:29]));
      chk(err == (rw[31:29] != 3'd0), "R8 err", 32'(err), 32'(rw[31:29] != 3'd0));
    end
    @(negedge clk);
    chk(done == 1'b0, "R11 done pulse", 32'(done), 32'd0);
    chk(req_ready == 1'b1, "R11 ready after", 32'(req_ready), 32'd1);
  endtask

  initial begin
    #(200000 * 10);
    wd_hit = 1'b1;
    errors++;
    checks++;
    $display("FAIL watchdog act=%0d exp=%0d", checks, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'd4242);
    repeat (3) @(negedge clk);
    chk(cs_n == 1'b1 && sclk == 1'b0, "R12 reset pins", {30'd0, cs_n, sclk}, 32'h2);
    chk(!busy && !done && req_ready, "R12 reset flags", {29'd0, busy, done, req_ready}, 32'h1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // directed corners
    run_txn(2'd0, 8'h00, 16'h0000, 32'h0800_0000 | (32'h1234 << 5), 1'b0);
    run_txn(2'd1, 8'h00, 16'h0000, 32'hFFFF_FFFF, 1'b0);
    run_txn(2'd1, 8'h00, 16'h0001, 32'h0, 1'b0);
    run_txn(2'd2, 8'h55, 16'hAAAA, 32'hE000_0000 | (32'h8000 << 10), 1'b0);
    run_txn(2'd3, 8'h00, 16'h0000, 32'h0C00_0000 | (32'h7FFF << 10), 1'b0);
    run_txn(2'd0, 8'hFF, 16'h0000, 32'h2000_0000 | (32'hFFFF << 5), 1'b1);
    run_txn(2'd1, 8'h12, 16'hFFFF, 32'h0, 1'b1);
    for (int n = 0; n < 40; n++) begin
      run_txn(2'($urandom % 4), 8'($urandom), 16'($urandom), $urandom, 1'($urandom % 2));
      if (wd_hit) break;
    end
    repeat (GUARD + 10) @(negedge clk);
    chk(sclk_bad == 0, "R4 sclk idle low", 32'(sclk_bad), 32'd0);
    chk(cs_n == 1'b1 && !busy, "R11 no stray frame", {30'd0, cs_n, busy}, 32'h2);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule